// File: doc/BRIEF.md
# Synchronous Serial Frame Master

This block is the master end of a clocked, frame-based serial link. It drives a bit clock towards a target device and sends one frame per word on a data-out line. Over the same bit clock, it collects the frame that the target returns on a data-in line. Each frame has a start bit, then 4 to 16 data bits, then an optional parity bit, then one or two stop bits. The clock runs only while a frame is in flight and rests high between frames. Its period equals one bit time, so the target needs no oversampling. The bit rate is set by a half-period count measured in system clock cycles.

Words arrive on a valid/ready transmit port and leave on a valid/ready receive port. Each received word carries a parity-error flag and a framing-error flag. Every accepted transmit word produces exactly one full-duplex frame, and that frame yields exactly one received word. A new frame starts only after the previous received word has been taken. The format inputs (width, parity mode, stop count, half period) are captured when a frame is accepted and stay fixed for that frame.

Top module: `usrt_master`

## Requirements
- R1: After reset, and whenever no frame is in flight, `ser_clk` and `ser_dout` are both 1, `rx_valid` is 0 and `tx_ready` is 1 unless a received word is still waiting.
- R2: A frame holds, in this order: a start bit of 0, the W data bits least significant bit first, the parity bit if enabled, and then the stop bits of value 1.
- R3: Each bit occupies 2×H system clock cycles. The clock is low for the first H cycles and high for the last H. H is `cfg_half` captured at frame acceptance, and 0 is taken as 1. The frame ends at the end of the high phase of its last bit.
- R4: `ser_dout` changes only in the cycle in which `ser_clk` falls. `ser_din` is sampled at the system clock edge on which `ser_clk` rises.
- R5: W is `cfg_width` clamped into 4..16. Transmit bits at positions W and above are ignored. `rx_data` bits at positions W and above read 0.
- R6: `cfg_parity` encoding: 00 no parity bit, 01 even (the parity bit makes the count of ones over data and parity even), 10 odd (that count is odd), 11 no parity bit.
- R7: `cfg_stop2` = 0 gives one stop bit and `cfg_stop2` = 1 gives two.
- R8: `rx_valid` rises in the cycle in which the frame ends. It stays high, with `rx_data`, `rx_perr` and `rx_ferr` held, until a cycle with `rx_ready` high.
- R9: `rx_perr` is 1 when parity is enabled and the sampled parity bit differs from the parity computed over the received data bits. Otherwise it is 0.
- R10: `rx_ferr` is 1 when any sampled stop bit is 0.
- R11: A word is accepted only when no frame is in flight and no received word is waiting. Format inputs that change during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 5 | Data bits per frame (clamped to 4..16) |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_half | input | 16 | Half bit period in system clock cycles |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block can start a frame |
| rx_data | output | 16 | Received word, zero above W |
| rx_perr | output | 1 | Parity mismatch on received word |
| rx_ferr | output | 1 | A received stop bit was 0 |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word taken |
| ser_clk | output | 1 | Bit clock to target, idle high |
| ser_dout | output | 1 | Serial data to target |
| ser_din | input | 1 | Serial data from target |

## Verification
The assertions assume that the target changes `ser_din` only while the bit clock is low, so a sample taken on a rising edge sees a settled level. The bench's target model drives `ser_din` only at the falling-clock slot of each bit. The assertions also assume that `rx_ready` is meaningful only while `rx_valid` is high. The bench raises it just for one cycle after checking the word, and also holds it low through stall windows while `tx_valid` is offered. The format inputs may move freely during a frame. One scenario scrambles them mid-frame to confirm that the captured values govern the frame.

// File: rtl/usrt_pkg.sv
package usrt_pkg;
  localparam int DW        = 16;
  localparam int MIN_W     = 4;
  localparam int WW        = 5;
  localparam int STOP_MAX  = 2;
  localparam int FRAME_MAX = 1 + DW + 1 + STOP_MAX;
  localparam int IW        = $clog2(FRAME_MAX);

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } par_e;

  typedef struct packed {
    logic [WW-1:0] width;
    par_e          par;
    logic          stop2;
  } fmt_t;

  function automatic logic [WW-1:0] clamp_width(input logic [WW-1:0] w);
    if (int'(w) < MIN_W) return WW'(MIN_W);
    if (int'(w) > DW)    return WW'(DW);
    return w;
  endfunction

  function automatic logic par_on(input par_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  function automatic logic [DW-1:0] width_mask(input logic [WW-1:0] w);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < int'(w));
    return m;
  endfunction

  function automatic logic [IW-1:0] frame_bits(input fmt_t f);
    return IW'(1) + IW'(f.width) + IW'(par_on(f.par)) + (f.stop2 ? IW'(2) : IW'(1));
  endfunction

  function automatic logic parity_of(input logic [DW-1:0] d, input logic [WW-1:0] w,
                                     input par_e p);
    logic x;
    x = ^(d & width_mask(w));
    return (p == PAR_ODD) ? ~x : x;
  endfunction

  // Level of frame slot idx for a given word and format.
  function automatic logic tx_bit_at(input logic [DW-1:0] d, input fmt_t f,
                                     input logic [IW-1:0] idx);
    logic b;
    b = 1'b1;
    if (idx == '0) b = 1'b0;
    for (int i = 0; i < DW; i++)
      if ((i < int'(f.width)) && (int'(idx) == i + 1)) b = d[i];
    if (par_on(f.par) && (int'(idx) == int'(f.width) + 1))
      b = parity_of(d, f.width, f.par);
    return b;
  endfunction

  function automatic logic slot_of(input logic [FRAME_MAX-1:0] s, input int pos);
    logic b;
    b = 1'b0;
    for (int i = 0; i < FRAME_MAX; i++)
      if (i == pos) b = s[i];
    return b;
  endfunction

  function automatic logic [DW-1:0] rx_word(input logic [FRAME_MAX-1:0] s,
                                            input logic [WW-1:0] w);
    logic [DW-1:0] d;
    for (int i = 0; i < DW; i++) d[i] = (i < int'(w)) ? s[i+1] : 1'b0;
    return d;
  endfunction

  function automatic logic rx_par_bad(input logic [FRAME_MAX-1:0] s, input fmt_t f);
    if (!par_on(f.par)) return 1'b0;
    return slot_of(s, int'(f.width) + 1) != parity_of(rx_word(s, f.width), f.width, f.par);
  endfunction

  function automatic logic rx_stop_bad(input logic [FRAME_MAX-1:0] s, input fmt_t f);
    int first;
    first = 1 + int'(f.width) + int'(par_on(f.par));
    return !slot_of(s, first) || (f.stop2 && !slot_of(s, first + 1));
  endfunction
endpackage

// File: rtl/usrt_bitclk.sv
module usrt_bitclk #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt,
  input  logic [HALF_W-1:0] half_lat,
  output logic              sclk,
  output logic              running,
  output logic              rise_evt,
  output logic              fall_evt
);
  logic [HALF_W-1:0] cnt;
  logic              phase_end;

  assign phase_end = running && (cnt == half_lat - 1'b1);
  assign rise_evt  = phase_end && !sclk;
  assign fall_evt  = phase_end && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      sclk    <= 1'b1;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
      sclk    <= 1'b0;
    end else if (running) begin
      if (phase_end) begin
        cnt <= '0;
        if (fall_evt && halt) running <= 1'b0;
        else                  sclk    <= ~sclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usrt_txpath.sv
module usrt_txpath
  import usrt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] load_word,
  input  fmt_t          fmt_lat,
  input  logic          advance,
  input  logic [IW-1:0] next_idx,
  output logic          dout
);
  logic [DW-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      dout <= 1'b1;
    end else if (start) begin
      word <= load_word;
      dout <= 1'b0;
    end else if (advance) begin
      dout <= tx_bit_at(word, fmt_lat, next_idx);
    end
  end
endmodule

// File: rtl/usrt_rxpath.sv
module usrt_rxpath
  import usrt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [IW-1:0] idx,
  input  logic          din,
  input  logic          finish,
  input  fmt_t          fmt_lat,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr,
  output logic          valid
);
  logic [FRAME_MAX-1:0] samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp <= '0;
    end else if (sample) begin
      for (int i = 0; i < FRAME_MAX; i++)
        if (int'(idx) == i) samp[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      valid <= 1'b0;
    end else if (finish) begin
      data  <= rx_word(samp, fmt_lat.width);
      perr  <= rx_par_bad(samp, fmt_lat);
      ferr  <= rx_stop_bad(samp, fmt_lat);
      valid <= 1'b1;
    end else if (valid && take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/usrt_master.sv
module usrt_master #(
  parameter int HALF_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [usrt_pkg::WW-1:0]   cfg_width,
  input  logic [1:0]                cfg_parity,
  input  logic                      cfg_stop2,
  input  logic [HALF_W-1:0]         cfg_half,
  input  logic [usrt_pkg::DW-1:0]   tx_data,
  input  logic                      tx_valid,
  output logic                      tx_ready,
  output logic [usrt_pkg::DW-1:0]   rx_data,
  output logic                      rx_perr,
  output logic                      rx_ferr,
  output logic                      rx_valid,
  input  logic                      rx_ready,
  output logic                      ser_clk,
  output logic                      ser_dout,
  input  logic                      ser_din
);
  import usrt_pkg::*;

  fmt_t              fmt_lat;
  logic [HALF_W-1:0] half_lat;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     last_idx;
  logic              busy;
  logic              start;
  logic              rise_evt;
  logic              fall_evt;
  logic              frame_end;
  logic              bit_step;

  assign tx_ready  = !busy && !rx_valid;
  assign start     = tx_valid && tx_ready;
  assign last_idx  = frame_bits(fmt_lat) - 1'b1;
  assign frame_end = fall_evt && (idx == last_idx);
  assign bit_step  = fall_evt && !frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_lat  <= '{width: WW'(MIN_W), par: PAR_NONE, stop2: 1'b0};
      half_lat <= HALF_W'(1);
      idx      <= '0;
    end else if (start) begin
      fmt_lat  <= '{width: clamp_width(cfg_width), par: par_e'(cfg_parity), stop2: cfg_stop2};
      half_lat <= (cfg_half == '0) ? HALF_W'(1) : cfg_half;
      idx      <= '0;
    end else if (bit_step) begin
      idx <= idx + 1'b1;
    end
  end

  usrt_bitclk #(.HALF_W(HALF_W)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .halt     (frame_end),
    .half_lat (half_lat),
    .sclk     (ser_clk),
    .running  (busy),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  usrt_txpath u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_word (tx_data),
    .fmt_lat   (fmt_lat),
    .advance   (bit_step),
    .next_idx  (idx + 1'b1),
    .dout      (ser_dout)
  );

  usrt_rxpath u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (rise_evt),
    .idx     (idx),
    .din     (ser_din),
    .finish  (frame_end),
    .fmt_lat (fmt_lat),
    .take    (rx_ready),
    .data    (rx_data),
    .perr    (rx_perr),
    .ferr    (rx_ferr),
    .valid   (rx_valid)
  );
endmodule

// File: rtl/usrt_master_chk.sv
module usrt_master_chk
  import usrt_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          ser_clk,
  input logic          ser_dout,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          busy,
  input logic          rise_evt,
  input logic          fall_evt,
  input logic          frame_end,
  input logic [WW-1:0] width_lat
);
  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_clk && ser_dout));

  // R4
  dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> $fell(ser_clk));

  // R3
  rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> ser_clk);

  // R3
  fall_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !frame_end) |=> !ser_clk);

  // R8
  end_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (rx_valid && !busy && ser_clk));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R11
  no_start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_ready);

  // R5
  rx_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data & ~width_mask(width_lat)) == '0));
endmodule

bind usrt_master usrt_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_clk   (ser_clk),
  .ser_dout  (ser_dout),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .busy      (busy),
  .rise_evt  (rise_evt),
  .fall_evt  (fall_evt),
  .frame_end (frame_end),
  .width_lat (fmt_lat.width)
);

// File: tb/test_usrt_master.sv
`timescale 1ns/1ps
module test_usrt_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_width = 5'd8;
  logic [1:0]  cfg_parity = 2'b00;
  logic        cfg_stop2 = 1'b0;
  logic [15:0] cfg_half = 16'd2;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] rx_data;
  logic        rx_perr, rx_ferr, rx_valid;
  logic        rx_ready = 1'b0;
  logic        ser_clk, ser_dout;
  logic        ser_din = 1'b1;

  int errors = 0;
  int checks = 0;
  int printed = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  int q[$];

  always #2.5 clk = ~clk;

  usrt_master i_usrt_master (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_parity(cfg_parity),
    .cfg_stop2(cfg_stop2), .cfg_half(cfg_half), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (printed < 30) $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      printed++;
    end
  endtask

  // Per-cycle model of the line: expected clock and data, plus the target's din.
  always @(negedge clk) begin
    int e;
    bit es, ed;
    if (mon_on) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        es = e[0]; ed = e[1];
        ser_din = e[2];
      end else begin
        es = 1'b1; ed = 1'b1;
        ser_din = 1'b1;
      end
      check(ser_clk == es, "R3", "ser_clk", int'(ser_clk), int'(es));
      check(ser_dout == ed, "R2,R4", "ser_dout", int'(ser_dout), int'(ed));
    end
  end

  function automatic int eff_width(input int w);
    return (w < 4) ? 4 : ((w > 16) ? 16 : w);
  endfunction

  task automatic do_frame(input logic [15:0] txw, input logic [15:0] rxw, input int w,
                          input int par, input bit s2, input int half,
                          input bit bad_par, input bit bad_stop, input bit upset,
                          input bit hold, input string req);
    int we, h, ones_t, ones_r;
    bit hp, pt, pr;
    logic [15:0] txm, rxm, held;
    logic txb[$];
    logic rxb[$];
    we = eff_width(w);
    h = (half == 0) ? 1 : half;
    hp = (par == 1) || (par == 2);
    txm = txw & 16'((32'd1 << we) - 1);
    rxm = rxw & 16'((32'd1 << we) - 1);
    ones_t = 0; ones_r = 0;
    txb.push_back(1'b0); rxb.push_back(1'b0);
    for (int i = 0; i < we; i++) begin
      txb.push_back(txm[i]); rxb.push_back(rxm[i]);
      ones_t += int'(txm[i]); ones_r += int'(rxm[i]);
    end
    if (hp) begin
      pt = (par == 2) ? !(ones_t % 2) : (ones_t % 2 == 1);
      pr = (par == 2) ? !(ones_r % 2) : (ones_r % 2 == 1);
      txb.push_back(pt); rxb.push_back(bad_par ? !pr : pr);
    end
    txb.push_back(1'b1); rxb.push_back(1'b1);
    if (s2) begin txb.push_back(1'b1); rxb.push_back(1'b1); end
    if (bad_stop) rxb[rxb.size()-1] = 1'b0;

    @(negedge clk);
    cfg_width = 5'(w); cfg_parity = 2'(par); cfg_stop2 = s2; cfg_half = 16'(half);
    tx_data = txw; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    for (int i = 0; i < txb.size(); i++)
      for (int c = 0; c < 2*h; c++)
        q.push_back(int'(c >= h) | (int'(txb[i]) << 1) | (int'(rxb[i]) << 2));
    @(negedge clk);
    tx_valid = 1'b0;
    if (upset) begin
      cfg_width = 5'd13; cfg_parity = 2'b10; cfg_stop2 = ~s2; cfg_half = 16'd7;
    end
    repeat (txb.size()*2*h - 1) @(negedge clk);
    check(rx_valid == 1'b0, "R8", {req, " rx_valid before end"}, int'(rx_valid), 0);
    @(negedge clk);
    check(rx_valid == 1'b1, "R8", {req, " rx_valid at end"}, int'(rx_valid), 1);
    check(rx_data == rxm, req, "rx_data", int'(rx_data), int'(rxm));
    check(rx_perr == (bad_par && hp), "R9", {req, " rx_perr"}, int'(rx_perr), int'(bad_par && hp));
    check(rx_ferr == bad_stop, "R10", {req, " rx_ferr"}, int'(rx_ferr), int'(bad_stop));
    check(tx_ready == 1'b0, "R11", {req, " tx_ready with word waiting"}, int'(tx_ready), 0);
    if (hold) begin
      held = rx_data;
      tx_data = 16'h1111; tx_valid = 1'b1;
      repeat (6) begin
        @(negedge clk);
        check(tx_ready == 1'b0, "R11", "stall tx_ready", int'(tx_ready), 0);
        check(rx_valid && rx_data == held, "R8", "held word", int'(rx_data), int'(held));
      end
      tx_valid = 1'b0;
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid == 1'b0, "R8", "rx_valid after take", int'(rx_valid), 0);
    check(tx_ready == 1'b1, "R1", "tx_ready after take", int'(tx_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_ready == 1'b1 && rx_valid == 1'b0, "R1", "reset handshake",
          int'({tx_ready, rx_valid}), 2);
    check(ser_clk && ser_dout, "R1", "reset line idle", int'({ser_clk, ser_dout}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    repeat (4) @(negedge clk);
    // R2 R3: plain 8-bit frame, no parity
    do_frame(16'h00A5, 16'h003C, 8, 0, 1'b0, 2, 0, 0, 0, 0, "R2");
    // R6: even parity
    do_frame(16'h0037, 16'h005A, 8, 1, 1'b0, 3, 0, 0, 0, 0, "R6");
    // R6 R7: odd parity with two stop bits, fastest clock
    do_frame(16'h0055, 16'h000F, 7, 2, 1'b1, 1, 0, 0, 0, 0, "R7");
    // R5: full 16-bit word
    do_frame(16'hBEEF, 16'h1234, 16, 1, 1'b1, 2, 0, 0, 0, 0, "R5");
    // R5: upper bits ignored at width 4
    do_frame(16'hFFF3, 16'hFFF6, 4, 0, 1'b0, 2, 0, 0, 0, 0, "R5");
    // R5: width below range clamps to 4
    do_frame(16'h00F9, 16'h00FA, 3, 1, 1'b0, 1, 0, 0, 0, 0, "R5");
    // R5: width above range clamps to 16
    do_frame(16'h8001, 16'hC003, 20, 2, 1'b0, 1, 0, 0, 0, 0, "R5");
    // R9: parity error injected by target
    do_frame(16'h0081, 16'h00C3, 8, 1, 1'b0, 2, 1, 0, 0, 0, "R9");
    // R10: bad single stop bit
    do_frame(16'h0012, 16'h0034, 8, 0, 1'b0, 2, 0, 1, 0, 0, "R10");
    // R10: bad second stop bit with odd parity
    do_frame(16'h0203, 16'h0304, 10, 2, 1'b1, 1, 0, 1, 0, 0, "R10");
    // R6: reserved parity code behaves as none
    do_frame(16'h006B, 16'h0029, 8, 3, 1'b0, 2, 1, 0, 0, 0, "R6");
    // R3: half period 0 runs as 1
    do_frame(16'h0009, 16'h0006, 6, 0, 1'b0, 0, 0, 0, 0, 0, "R3");
    // R11: format scrambled mid-frame
    do_frame(16'h0C3A, 16'h0A5C, 12, 1, 1'b0, 2, 0, 0, 1, 0, "R11");
    // R11 R8: tx offered while a word waits
    do_frame(16'h004E, 16'h00E4, 8, 2, 1'b0, 2, 0, 0, 0, 1, "R11");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule